// File: doc/BRIEF.md
# Shared Address/Data Bus Memory Bridge

This bridge connects a pin-limited tester to an SRAM whose separate address and data buses need more lines than the tester offers. The tester uses one shared bus of `BUS_W` lines for both address and data, at different times. A small control port tells the bridge what to do with the bus. On an address strobe the bridge latches the low `ADDR_W` bus bits and holds them on the memory address pins. A chip-select then starts one memory access. The data-direction line picks the kind of access. For a write, the bridge captures the write data from the bus and drives it to the memory while it pulses the write strobe. For a read, it samples the memory's read data into the same latch. It then returns that data onto the shared bus, but only while the tester asserts the output-control line.

Both strobe widths are counted in system clocks. `RD_CYC` and `WR_CYC` are set so that the 400 ns read cycle and the 500 ns write cycle are met. At 250 MHz the defaults of 100 and 125 clocks meet them exactly.

The sequencer has four states:
- `ST_IDLE`: ready for a command.
- `ST_WRITE`: write strobe active.
- `ST_READ`: read access active.
- `ST_HOLD`: captured read data is valid.

The transitions are:
- From IDLE or HOLD, an address strobe goes to IDLE.
- From IDLE or HOLD, a chip-select with the direction line at 1 goes to WRITE.
- From IDLE or HOLD, a chip-select with the direction line at 0 goes to READ.
- From WRITE, when the cycle count expires, the state goes to IDLE.
- From READ, when the cycle count expires, the state goes to HOLD and the read data is captured.

Top module: `adbus_bridge`

## Requirements
- R1: After reset, `mem_act`, `mem_rw`, `rd_valid` and `tst_bus_oe` are 0, and `mem_addr` and `mem_wdata` are 0.
- R2: In IDLE or HOLD, `ctl_astb` sampled high loads `tst_bus_in[ADDR_W-1:0]` onto `mem_addr` one clock later. The upper bus bits are ignored.
- R3: When `ctl_astb` and `ctl_cs` are high in the same clock, the address strobe wins and no access starts.
- R4: In IDLE or HOLD, `ctl_cs` with `ctl_dir`=1 (1 = write, 0 = read) captures `tst_bus_in[DATA_W-1:0]` onto `mem_wdata`. Starting the next clock, `mem_act`=1 and `mem_rw`=1 for exactly `WR_CYC` clocks.
- R5: In IDLE or HOLD, `ctl_cs` with `ctl_dir`=0 drives `mem_act`=1 and `mem_rw`=0 for exactly `RD_CYC` clocks starting the next clock. `mem_rdata` is captured on the last of those clocks.
- R6: `rd_valid` rises on the clock after a read access ends. It stays high until the next address strobe or chip-select is accepted.
- R7: `tst_bus_oe` is 1 only while `rd_valid`=1, `ctl_oe`=1 and `ctl_dir`=0. While it is 1, `tst_bus_out` carries the captured read data, zero-extended to `BUS_W`.
- R8: Address strobes and chip-selects that arrive while `mem_act`=1 are ignored.
- R9: `mem_addr` and `mem_wdata` stay constant for the whole of an access.
- R10: `tst_bus_oe` and `mem_act` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tst_bus_in | input | BUS_W | Shared bus value driven by the tester |
| tst_bus_out | output | BUS_W | Read data returned to the shared bus |
| tst_bus_oe | output | 1 | Bridge drives the shared bus when 1 |
| ctl_astb | input | 1 | Address strobe |
| ctl_dir | input | 1 | Data direction, 1 = write, 0 = read |
| ctl_cs | input | 1 | Chip-select: start an access |
| ctl_oe | input | 1 | Output control for read-back |
| mem_addr | output | ADDR_W | Latched memory address |
| mem_wdata | output | DATA_W | Data latch contents toward memory |
| mem_rdata | input | DATA_W | Read data from memory |
| mem_rw | output | 1 | Write strobe and write-data drive enable |
| mem_act | output | 1 | Access in progress |
| rd_valid | output | 1 | Captured read data valid |

## Verification
The bench builds the bridge with `RD_CYC`=6 and `WR_CYC`=9, with the default 24/18/18 widths. With these short strobe counts, dozens of complete random write and read accesses fit in a short run. Each strobe width is measured to the exact clock. Because the two counts differ, a read timed with the write count, or the reverse, shows up. Commands injected in the middle of an access check that busy-state inputs are ignored. Same-cycle strobe and select checks the priority rule.

// File: rtl/adbus_pkg.sv
package adbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_HOLD  = 2'd3
    } br_state_t;
endpackage

// File: rtl/adbus_seq.sv
module adbus_seq
    import adbus_pkg::*;
#(
    parameter int RD_CYC = 100,
    parameter int WR_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_astb,
    input  logic ctl_dir,
    input  logic ctl_cs,
    input  logic ctl_oe,
    output logic addr_ld,
    output logic wr_ld,
    output logic rd_ld,
    output logic mem_act,
    output logic mem_rw,
    output logic rd_valid,
    output logic bus_oe
);
    localparam int MAX_CYC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    br_state_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state and latch load pulses
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        addr_ld = 1'b0;
        wr_ld   = 1'b0;
        rd_ld   = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_HOLD: begin
                if (ctl_astb) begin
                    addr_ld = 1'b1;
                    st_d    = ST_IDLE;
                end else if (ctl_cs) begin
                    if (ctl_dir) begin
                        wr_ld = 1'b1;
                        st_d  = ST_WRITE;
                        cnt_d = CNT_W'(WR_CYC - 1);
                    end else begin
                        st_d  = ST_READ;
                        cnt_d = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_WRITE: begin
                if (cnt_q == '0) st_d = ST_IDLE;
                else             cnt_d = cnt_q - 1'b1;
            end
            ST_READ: begin
                if (cnt_q == '0) begin
                    rd_ld = 1'b1;
                    st_d  = ST_HOLD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    // state-decoded outputs
    always_comb begin
        mem_act  = (st_q == ST_WRITE) || (st_q == ST_READ);
        mem_rw   = (st_q == ST_WRITE);
        rd_valid = (st_q == ST_HOLD);
        bus_oe   = (st_q == ST_HOLD) && ctl_oe && !ctl_dir;
    end
endmodule

// File: rtl/adbus_latch.sv
module adbus_latch #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_ld,
    input  logic              wr_ld,
    input  logic              rd_ld,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (addr_ld) addr_q <= addr_in;
            if (wr_ld)      data_q <= wdata_in;
            else if (rd_ld) data_q <= rdata_in;
        end
    end
endmodule

// File: rtl/adbus_bridge.sv
module adbus_bridge #(
    parameter int BUS_W  = 24,
    parameter int ADDR_W = 18,
    parameter int DATA_W = 18,
    parameter int RD_CYC = 100,
    parameter int WR_CYC = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  tst_bus_in,
    output logic [BUS_W-1:0]  tst_bus_out,
    output logic              tst_bus_oe,
    input  logic              ctl_astb,
    input  logic              ctl_dir,
    input  logic              ctl_cs,
    input  logic              ctl_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rw,
    output logic              mem_act,
    output logic              rd_valid
);
    logic addr_ld, wr_ld, rd_ld;

    adbus_seq #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_astb (ctl_astb),
        .ctl_dir  (ctl_dir),
        .ctl_cs   (ctl_cs),
        .ctl_oe   (ctl_oe),
        .addr_ld  (addr_ld),
        .wr_ld    (wr_ld),
        .rd_ld    (rd_ld),
        .mem_act  (mem_act),
        .mem_rw   (mem_rw),
        .rd_valid (rd_valid),
        .bus_oe   (tst_bus_oe)
    );

    adbus_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_ld  (addr_ld),
        .wr_ld    (wr_ld),
        .rd_ld    (rd_ld),
        .addr_in  (tst_bus_in[ADDR_W-1:0]),
        .wdata_in (tst_bus_in[DATA_W-1:0]),
        .rdata_in (mem_rdata),
        .addr_q   (mem_addr),
        .data_q   (mem_wdata)
    );

    assign tst_bus_out = BUS_W'(mem_wdata);
endmodule

// File: rtl/adbus_chk.sv
module adbus_chk #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 18,
    parameter int RD_CYC = 100,
    parameter int WR_CYC = 125
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_oe,
    input logic              tst_bus_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_rw,
    input logic              mem_act,
    input logic              rd_valid
);
    logic [31:0] act_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       act_run <= '0;
        else if (mem_act) act_run <= act_run + 1;
        else              act_run <= '0;
    end

    // R10
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tst_bus_oe |-> !mem_act);

    // R7
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tst_bus_oe |-> (ctl_oe && rd_valid));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_act && $past(mem_act)) |-> $stable(mem_addr));

    // R9
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rw && $past(mem_rw)) |-> $stable(mem_wdata));

    // R4
    wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_act) && $past(mem_rw)) |-> (act_run == WR_CYC));

    // R5
    rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_act) && !$past(mem_rw)) |-> (act_run == RD_CYC));

    // R6
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(mem_act && !mem_rw));
endmodule

bind adbus_bridge adbus_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_oe     (ctl_oe),
    .tst_bus_oe (tst_bus_oe),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rw     (mem_rw),
    .mem_act    (mem_act),
    .rd_valid   (rd_valid)
);

// File: tb/adbus_bridge_tb.sv
module adbus_bridge_tb_top;
    localparam int BW = 24, AW = 18, DW = 18, RDC = 6, WRC = 9;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic [BW-1:0] bus_in = '0, bus_out;
    logic          bus_oe, astb = 0, dir = 0, cs = 0, oe = 0;
    logic [AW-1:0] maddr;
    logic [DW-1:0] mwdata, mrdata;
    logic          mrw, mact, rvalid;
    int            total = 0, bad = 0;
    logic          done = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
        return {a[8:0], a[17:9]} ^ 18'h15A3C;
    endfunction

    assign mrdata = mem_fn(maddr);

    adbus_bridge #(.BUS_W(BW), .ADDR_W(AW), .DATA_W(DW), .RD_CYC(RDC), .WR_CYC(WRC)) dut_i (
        .clk(clk), .rst_n(rst_n), .tst_bus_in(bus_in), .tst_bus_out(bus_out),
        .tst_bus_oe(bus_oe), .ctl_astb(astb), .ctl_dir(dir), .ctl_cs(cs), .ctl_oe(oe),
        .mem_addr(maddr), .mem_wdata(mwdata), .mem_rdata(mrdata), .mem_rw(mrw),
        .mem_act(mact), .rd_valid(rvalid));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_addr(input logic [BW-1:0] v);
        @(negedge clk); bus_in = v; astb = 1;
        @(negedge clk); astb = 0; bus_in = $urandom;
        chk(maddr == v[AW-1:0], "R2 addr latch", 32'(maddr), 32'(v[AW-1:0]));
        chk(!rvalid, "R6 valid cleared by strobe", 32'(rvalid), 0);
    endtask

    // run one access; noise=1 injects commands during the busy window
    task automatic do_access(input bit wr, input logic [BW-1:0] v, input bit noise);
        logic [AW-1:0] a0;
        int n;
        a0 = maddr;
        @(negedge clk); bus_in = v; dir = wr; cs = 1;
        @(negedge clk); cs = 0;
        n = 0;
        while (mact && n < 1000) begin
            if (wr) chk(mrw && mwdata == v[DW-1:0], "R4 write strobe/data", 32'(mwdata), 32'(v[DW-1:0]));
            else    chk(!mrw, "R5 read strobe", 32'(mrw), 0);
            chk(maddr == a0, "R9 addr steady", 32'(maddr), 32'(a0));
            if (noise) begin
                bus_in = $urandom; astb = 1'($urandom); cs = 1'($urandom); dir = 1'($urandom);
            end
            n++;
            @(negedge clk);
        end
        astb = 0; cs = 0; dir = 0;
        chk(n == (wr ? WRC : RDC), wr ? "R4 write width" : "R5 read width", 32'(n), wr ? WRC : RDC);
        chk(maddr == a0, "R8 busy commands ignored", 32'(maddr), 32'(a0));
        if (!wr) begin
            chk(rvalid, "R6 valid after read", 32'(rvalid), 1);
            chk(!bus_oe, "R7 no drive without oe", 32'(bus_oe), 0);
            oe = 1; #1;
            chk(bus_oe && bus_out == BW'(mem_fn(a0)), "R7/R5 read-back", bus_out, 32'(mem_fn(a0)));
            dir = 1; #1;
            chk(!bus_oe, "R7 no drive with dir=1", 32'(bus_oe), 0);
            dir = 0; oe = 0;
            @(negedge clk);
            chk(rvalid, "R6 valid held", 32'(rvalid), 1);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED));
        #1;
        chk(!mact && !mrw && !rvalid && !bus_oe && maddr == 0 && mwdata == 0, "R1 reset", 32'(maddr), 0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        do_addr(24'hFC0123);
        do_access(1, 24'hAB3FFF, 0);
        do_access(0, 24'h000000, 0);
        do_addr(24'h03FFFF);
        do_access(0, 24'h0, 1);
        do_access(1, 24'hFFFFFF, 1);
        // R3: strobe and select together
        @(negedge clk); bus_in = 24'h012345; astb = 1; cs = 1; dir = 1;
        @(negedge clk); astb = 0; cs = 0; dir = 0;
        chk(!mact && maddr == 18'h12345, "R3 strobe priority", 32'(maddr), 32'h12345);
        for (int i = 0; i < 40; i++) begin
            do_addr(24'($urandom));
            do_access(1'($urandom), 24'($urandom), 1'($urandom));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                bad++; total++;
                $display("FAIL watchdog actual=hung expected=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule